// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One counter channel that counts down from a loaded start value and drives a waveform output in one of six modes. A counting-tick enable sets the rate. Each tick advances the channel by one step, and every other clock cycle holds its state.

A separate host-access block writes the channel. One load strobe carries the start value, the mode and a decimal-count flag, and the load restarts the channel. The access block also reads the live count and the stored configuration back from the channel; byte sequencing and snapshot latching are left to it.

A gate input restarts counting on its rising edge, but only in the modes that allow it. A start value of zero stands for the full 16-bit range plus one.

Top module: `ctc_channel`

## Requirements
- R1: Loading a start value of 0 sets the period to 65536 ticks: the output rises after exactly 65536 ticks in mode 0, and the readable count is 0 right after the load and 1 after 65535 ticks.
- R2: A load takes priority over a gate edge and over a tick. It restarts the elapsed-tick measure from zero, so in the cycle after the load the readable count equals the loaded value and the output reflects zero elapsed ticks.
- R3: Mode 0: the output is low while the elapsed ticks are below the period and high from then on. Only a load brings it low again.
- R4: Mode 1: the output is high while the elapsed ticks are below the period and low from then on.
- R5: Mode 2: the output is high for exactly one tick whenever the elapsed ticks are a nonzero multiple of the period, and low otherwise.
- R6: Mode 3: in each period the output is high for the first (period+1)/2 ticks and low for the rest, so an odd period has the longer high phase.
- R7: Modes 4 and 5: the output is high only in the one tick where the elapsed ticks equal the period, and low before and after it.
- R8: In modes 1, 2, 3 and 5, a rising edge on gate_i restarts counting from the loaded value. In modes 0 and 4 a gate edge changes neither the output nor the readable count.
- R9: In modes 0, 1, 4 and 5 the readable count is (period - elapsed) mod 65536, and it keeps wrapping after the terminal point.
- R10: In mode 2 the readable count is period - (elapsed mod period). In mode 3 it is period - ((2*elapsed) mod period), so it drops by two per tick and wraps inside the period. In both modes a value of 65536 reads as 0.
- R11: Mode codes 6 and 7 behave as modes 2 and 3 (3'b110 acts as 3'b010 and 3'b111 acts as 3'b011). mode_o reports the raw 3-bit code as it was loaded.
- R12: The decimal-count flag is stored and reported on bcd_o, and it has no effect on the count or on the output.
- R13: The channel advances only in cycles where tick_i is high. In all other cycles the count and the output hold.
- R14: After reset the channel is in mode 3 with a period of 65536: wave_o=1, count_o=0, mode_o=3, bcd_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counting-tick enable |
| load_i | input | 1 | Load strobe for the start value and configuration |
| load_count_i | input | 16 | Start value; 0 means 65536 |
| load_mode_i | input | 3 | Mode code 0..7 |
| load_bcd_i | input | 1 | Decimal-count flag, stored only |
| gate_i | input | 1 | Gate; a rising edge retriggers in modes 1, 2, 3 and 5 |
| wave_o | output | 1 | Waveform output |
| count_o | output | 16 | Live readable count |
| mode_o | output | 3 | Stored raw mode code |
| bcd_o | output | 1 | Stored decimal-count flag |

## Verification
Every mode is driven through its terminal point and past it, with small periods so that each phase boundary is checked tick by tick.

- An odd period (5) and an even period (4) in mode 3 separate the correct high-phase length from a floor-halved one.
- In modes 0 and 4, counting well past the terminal point exposes any saturation of the readable count.
- A gate pulse is applied in every mode. This separates the modes that retrigger from those that ignore the gate.
- The same period is loaded with the decimal-count flag set and with it clear. Aliased mode codes 6 and 7 are run through the same ticks as codes 2 and 3.
- A zero load is counted through all 65536 ticks.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic mode_e norm_mode(logic [2:0] raw);
    if (raw[2:1] == 2'b11) return mode_e'({1'b0, raw[1:0]});
    return mode_e'(raw);
  endfunction

  function automatic logic is_periodic(mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic gate_retrig(mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

endpackage

// File: rtl/ctc_elapsed.sv
module ctc_elapsed #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             periodic_i,
  input  logic [CNT_W:0]   period_i,
  output logic [CNT_W:0]   phase_o,
  output logic             wrapped_o,
  output logic [CNT_W-1:0] since_o
);

  logic [CNT_W:0] phase_q;
  logic           wrapped_q;
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      wrapped_q <= 1'b0;
      since_q   <= '0;
    end else if (restart_i) begin
      phase_q   <= '0;
      wrapped_q <= 1'b0;
      since_q   <= '0;
    end else if (tick_i) begin
      since_q <= since_q + 1'b1;
      if (periodic_i) begin
        if (phase_q == period_i - 1'b1) begin
          phase_q   <= '0;
          wrapped_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end else if (phase_q <= period_i) begin
        // saturate at period+1: enough to tell before/at/after
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_o   = phase_q;
  assign wrapped_o = wrapped_q;
  assign since_o   = since_q;

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> ($stable(phase_o) && $stable(since_o)));

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_o == '0 && since_o == '0 && !wrapped_o));

  a_r5_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periodic_i |-> (phase_o < period_i));

endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           restart_i,
  input  mode_e          mode_i,
  input  logic [CNT_W:0] period_i,
  input  logic [CNT_W:0] phase_i,
  input  logic           wrapped_i,
  output logic           wave_o
);

  logic [CNT_W:0] half;
  assign half = (period_i + 1'b1) >> 1;

  always_comb begin
    unique case (mode_i)
      M_TERM:          wave_o = (phase_i >= period_i);
      M_ONESHOT:       wave_o = (phase_i < period_i);
      M_RATE:          wave_o = wrapped_i && (phase_i == '0);
      M_SQUARE:        wave_o = (phase_i < half);
      M_SWSTB, M_HWSTB: wave_o = (phase_i == period_i);
      default:         wave_o = 1'b0;
    endcase
  end

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_TERM && wave_o && !restart_i) |=> wave_o);

  a_r5_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_RATE && wave_o && tick_i && !restart_i && period_i > 1) |=> !wave_o);

  a_r7_strobe_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_SWSTB || mode_i == M_HWSTB) && wave_o && tick_i && !restart_i) |=> !wave_o);

endmodule

// File: rtl/ctc_readback.sv
module ctc_readback
  import ctc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   period_i,
  input  logic [CNT_W:0]   phase_i,
  input  logic [CNT_W-1:0] since_i,
  output logic [CNT_W-1:0] value_o
);

  logic [CNT_W+1:0] two_p;
  logic [CNT_W+1:0] per_x;
  logic [CNT_W+1:0] two_mod;
  logic [CNT_W:0]   sq_val;
  logic [CNT_W:0]   rt_val;

  assign two_p   = {phase_i, 1'b0};
  assign per_x   = {1'b0, period_i};
  assign two_mod = (two_p >= per_x) ? (two_p - per_x) : two_p;
  assign sq_val  = period_i - two_mod[CNT_W:0];
  assign rt_val  = period_i - phase_i;

  always_comb begin
    unique case (mode_i)
      M_RATE:   value_o = rt_val[CNT_W-1:0];
      M_SQUARE: value_o = sq_val[CNT_W-1:0];
      default:  value_o = period_i[CNT_W-1:0] - since_i;
    endcase
  end

endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_count_i,
  input  logic [2:0]       load_mode_i,
  input  logic             load_bcd_i,
  input  logic             gate_i,
  output logic             wave_o,
  output logic [CNT_W-1:0] count_o,
  output logic [2:0]       mode_o,
  output logic             bcd_o
);

  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0]   period_q;
  logic [2:0]       mode_raw_q;
  logic             bcd_q;
  logic             gate_q;
  mode_e            mode;
  logic             gate_rise;
  logic             restart;
  logic [CNT_W:0]   phase;
  logic             wrapped;
  logic [CNT_W-1:0] since;

  assign mode      = norm_mode(mode_raw_q);
  assign gate_rise = gate_i && !gate_q;
  assign restart   = load_i || (gate_rise && gate_retrig(mode));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q   <= FULL;
      mode_raw_q <= 3'd3;
      bcd_q      <= 1'b0;
      gate_q     <= 1'b1;
    end else begin
      gate_q <= gate_i;
      if (load_i) begin
        period_q   <= (load_count_i == '0) ? FULL : {1'b0, load_count_i};
        mode_raw_q <= load_mode_i;
        bcd_q      <= load_bcd_i;
      end
    end
  end

  ctc_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .restart_i  (restart),
    .periodic_i (is_periodic(mode)),
    .period_i   (period_q),
    .phase_o    (phase),
    .wrapped_o  (wrapped),
    .since_o    (since)
  );

  ctc_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart),
    .mode_i    (mode),
    .period_i  (period_q),
    .phase_i   (phase),
    .wrapped_i (wrapped),
    .wave_o    (wave_o)
  );

  ctc_readback #(.CNT_W(CNT_W)) u_readback (
    .mode_i   (mode),
    .period_i (period_q),
    .phase_i  (phase),
    .since_i  (since),
    .value_o  (count_o)
  );

  assign mode_o = mode_raw_q;
  assign bcd_o  = bcd_q;

  a_r1_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_count_i == '0) |=> (period_q == FULL));

  a_r8_no_retrig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_rise && !load_i && !tick_i && (mode == M_TERM || mode == M_SWSTB))
      |=> ($stable(count_o) && $stable(wave_o)));

  a_r2_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_count_i != '0) |=> (count_o == $past(load_count_i)));

endmodule

// File: tb/ctc_channel_test.sv
module ctc_channel_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_count_i = '0;
  logic [2:0]  load_mode_i = '0;
  logic        load_bcd_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        wave_o;
  logic [15:0] count_o;
  logic [2:0]  mode_o;
  logic        bcd_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctc_channel uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(load_i),
    .load_count_i(load_count_i), .load_mode_i(load_mode_i), .load_bcd_i(load_bcd_i),
    .gate_i(gate_i), .wave_o(wave_o), .count_o(count_o), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk2(string req, int w, int c);
    chk(req, int'(wave_o), w);
    chk(req, int'(count_o), c);
  endtask

  task automatic do_load(int val, int mode, bit bcd);
    load_i = 1'b1; load_count_i = val[15:0]; load_mode_i = mode[2:0]; load_bcd_i = bcd;
    tick_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_i = 1'b1;
    @(negedge clk);
    gate_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R14 wave", int'(wave_o), 1);
    chk("R14 count", int'(count_o), 0);
    chk("R14 mode", int'(mode_o), 3);
    chk("R14 bcd", int'(bcd_o), 0);
  endtask

  task automatic t_mode0();
    do_load(5, 0, 0);          chk2("R2 R3 load", 0, 5);
    repeat (3) @(negedge clk); chk2("R13 idle", 0, 5);
    ticks(4);                  chk2("R3 before", 0, 1);
    ticks(1);                  chk2("R3 reach", 1, 0);
    ticks(2);                  chk2("R9 wrap", 1, 16'hFFFE);
    gate_pulse();              chk2("R8 mode0 gate", 1, 16'hFFFE);
    ticks(2); do_load(3, 0, 0); chk2("R2 reload", 0, 3);
  endtask

  task automatic t_mode1();
    do_load(3, 1, 0);  chk2("R4 load", 1, 3);
    ticks(2);          chk2("R4 mid", 1, 1);
    ticks(1);          chk2("R4 end", 0, 0);
    gate_pulse();      chk2("R8 mode1 retrig", 1, 3);
    ticks(3);          chk2("R4 end again", 0, 0);
  endtask

  task automatic t_mode2(int code, bit bcd);
    do_load(4, code, bcd); chk2("R5 load", 0, 4);
    chk("R12 bcd", int'(bcd_o), int'(bcd));
    chk("R11 mode_o", int'(mode_o), code);
    ticks(3);  chk2("R5 R10 pre", 0, 1);
    ticks(1);  chk2("R5 pulse", 1, 4);
    ticks(1);  chk2("R5 after", 0, 3);
    ticks(3);  chk2("R5 pulse2", 1, 4);
    gate_pulse(); chk2("R8 mode2 retrig", 0, 4);
  endtask

  task automatic t_mode3(int code);
    do_load(5, code, 0); chk2("R6 R10 e0", 1, 5);
    ticks(1); chk2("R6 R10 e1", 1, 3);
    ticks(1); chk2("R6 R10 e2", 1, 1);
    ticks(1); chk2("R6 R10 e3", 0, 4);
    ticks(1); chk2("R6 R10 e4", 0, 2);
    ticks(1); chk2("R6 R10 e5", 1, 5);
    ticks(2); gate_pulse(); chk2("R8 mode3 retrig", 1, 5);
    do_load(4, code, 0);
    ticks(1); chk2("R6 even e1", 1, 2);
    ticks(1); chk2("R6 even e2", 0, 4);
    ticks(1); chk2("R6 even e3", 0, 2);
  endtask

  task automatic t_mode4();
    do_load(2, 4, 0); chk2("R7 load", 0, 2);
    ticks(1); chk2("R7 before", 0, 1);
    ticks(1); chk2("R7 strobe", 1, 0);
    ticks(1); chk2("R7 R9 after", 0, 16'hFFFF);
    gate_pulse(); chk2("R8 mode4 gate", 0, 16'hFFFF);
  endtask

  task automatic t_mode5();
    do_load(2, 5, 0);
    ticks(2); chk2("R7 m5 strobe", 1, 0);
    ticks(1); chk2("R7 m5 after", 0, 16'hFFFF);
    gate_pulse(); chk2("R8 mode5 retrig", 0, 2);
    ticks(2); chk2("R7 m5 strobe again", 1, 0);
  endtask

  task automatic t_zero();
    do_load(0, 0, 0);  chk2("R1 load", 0, 0);
    ticks(65535);      chk2("R1 near", 0, 1);
    ticks(1);          chk2("R1 reach", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2(2, 0);
    t_mode2(2, 1);   // R12 flag set, same waveform
    t_mode2(6, 0);   // R11 alias
    t_mode3(3);
    t_mode3(7);      // R11 alias
    t_mode4();
    t_mode5();
    t_zero();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule